// File: doc/BRIEF.md
# Instruction-fetch fence sequencer

This block sits next to the decode, fetch and memory stages of a simple in-order core. It watches the decoded-instruction stream for the instruction-fetch fence. When one is accepted, it stops issue and runs a fixed sequence so that any fetch after the fence sees every store this hart made visible before it. The block only orders the local hart's own fetches. It has no signal that reaches other harts.

The sequence always starts by waiting for the store buffer to drain and always ends with a one-cycle fetch-pipeline flush. The flush redirects fetch to the address that follows the fence. A build-time parameter selects one of two cache configurations:

- **Coherent caches, or no caches:** the sequence goes straight from the drain to the flush.
- **Incoherent caches:** the sequence first has the data cache fully written back and then has the instruction cache fully invalidated. Each of these steps holds its request until the cache reports done.

Top module: `ifence_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge `dec_ready` is 1, and `dc_wb_req`, `ic_inv_req` and `fetch_flush` are 0. This also holds when reset arrives in the middle of a sequence.
- R2: An instruction is accepted as a fetch fence only when `dec_valid` and `dec_ready` are both 1 at a rising edge, its bits [6:0] are 7'b0001111 and its bits [14:12] are 3'b001. A fence instruction presented with `dec_valid` low has no effect.
- R3: An instruction on the same major opcode with bits [14:12] other than 3'b001 does nothing in this block. This includes the ordinary data fence, 3'b000. An instruction with any other opcode also does nothing. In both cases `dec_ready` stays 1 and no request or flush appears.
- R4: The contents of bits [31:15] and [11:7] of the fence do not change the sequence or its timing.
- R5: `dec_ready` is 0 from the cycle after acceptance through the flush cycle.
- R6: The sequence does not leave the drain step while `sb_empty` is 0. The first cache request, or the flush in coherent mode, comes only after `sb_empty` has been sampled high.
- R7: With incoherent caches, `dc_wb_req` rises first and stays high until `dc_wb_done` is sampled high. `ic_inv_req` then rises and stays high until `ic_inv_done` is sampled high. The flush follows, and the two requests are never high together.
- R8: With coherent caches, `dc_wb_req` and `ic_inv_req` never go high.
- R9: `fetch_flush` is high for exactly one cycle per fence. During that cycle `fetch_redirect_pc` equals the fence's PC plus 4, modulo 2^PC_W. `dec_ready` returns to 1 in the following cycle.
- R10: With coherent caches and `sb_empty` already 1, `fetch_flush` is high in the second cycle after the acceptance cycle.
- R11: A fence presented in the first cycle that `dec_ready` is back at 1 is accepted and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decoded instruction is valid |
| dec_ready | output | 1 | Block is idle and can take an instruction |
| dec_instr | input | 32 | Decoded instruction word |
| dec_pc | input | PC_W | Address of the decoded instruction |
| sb_empty | input | 1 | Store buffer holds no pending stores |
| dc_wb_req | output | 1 | Request a full data-cache write-back |
| dc_wb_done | input | 1 | Data-cache write-back finished |
| ic_inv_req | output | 1 | Request a full instruction-cache invalidate |
| ic_inv_done | input | 1 | Instruction-cache invalidate finished |
| fetch_flush | output | 1 | One-cycle flush of the fetch pipeline |
| fetch_redirect_pc | output | PC_W | Fetch restart address, valid with the flush |

## Verification
The bench sweeps the drain delay, the write-back latency and the invalidate latency, including done in the same cycle as the request. A sequencer that skipped a wait, or dropped a request early, would flush on the wrong cycle or raise the invalidate before the write-back had finished.

Non-fence instructions are swept across every funct3 on the fence opcode and across neighbouring opcodes. A decoder that looked at too few bits would stall issue on the data fence.

Other runs cover:
- a PC at the top of the address space, which catches a redirect adder of the wrong width;
- reset arriving mid-request, which catches a request left hanging;
- fences presented back to back, which catches a sequencer that misses the fence offered on the cycle it returns to idle.

// File: rtl/ifs_pkg.sv
// Package: shared encodings and state type for the fetch fence sequencer.
// Assumes 32-bit base instruction words with opcode in [6:0], funct3 in [14:12].
package ifs_pkg;

    localparam int INSTR_W = 32;
    localparam int INSTR_BYTES = INSTR_W / 8;

    localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
    localparam logic [2:0] F3_FETCH_FENCE = 3'b001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_DCWB,
        ST_ICINV,
        ST_FLUSH
    } seq_state_e;

endpackage

// File: rtl/ifs_decode.sv
// Module: ifs_decode
// Recognises the instruction-fetch fence from opcode and funct3 only.
// Assumes: the immediate, rs1 and rd fields are reserved and must not affect
// the result, so they are deliberately left out of the comparison.
module ifs_decode
    import ifs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_fetch_fence
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic       unused_fields;

    // Split out the two fields that select the fence.
    assign opcode = instr[6:0];
    assign funct3 = instr[14:12];

    // Reserved fields are intentionally not decoded.
    assign unused_fields = ^{instr[31:15], instr[11:7]};

    // Match only the fetch fence; the data fence (funct3 000) falls through.
    always_comb begin
        is_fetch_fence = (opcode == OPC_MISC_MEM) && (funct3 == F3_FETCH_FENCE);
    end

endmodule

// File: rtl/ifs_seq_fsm.sv
// Module: ifs_seq_fsm
// Walks the fence sequence: drain stores, optional cache write-back and
// invalidate, then a single flush cycle. Cache requests are decoded from state
// and therefore held until the matching done is sampled.
// Assumes: done inputs are only meaningful while the matching request is high.
module ifs_seq_fsm
    import ifs_pkg::*;
#(
    parameter bit COHERENT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sb_empty,
    input  logic dc_done,
    input  logic ic_done,
    output logic idle,
    output logic dc_req,
    output logic ic_req,
    output logic flush
);

    seq_state_e state_q;
    seq_state_e state_nx;
    seq_state_e drain_next;

    // The cache configuration picks where the drain step leads.
    generate
        if (COHERENT) begin : g_coherent
            assign drain_next = ST_FLUSH;
        end else begin : g_incoherent
            assign drain_next = ST_DCWB;
        end
    endgenerate

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state selection for each step of the sequence.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_nx = ST_DRAIN;
            ST_DRAIN: if (sb_empty) state_nx = drain_next;
            ST_DCWB:  if (dc_done)  state_nx = ST_ICINV;
            ST_ICINV: if (ic_done)  state_nx = ST_FLUSH;
            ST_FLUSH:               state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // Outputs are pure state decodes so each lasts exactly as long as its step.
    always_comb begin
        idle   = (state_q == ST_IDLE);
        dc_req = (state_q == ST_DCWB);
        ic_req = (state_q == ST_ICINV);
        flush  = (state_q == ST_FLUSH);
    end

endmodule

// File: rtl/ifs_redirect.sv
// Module: ifs_redirect
// Captures the PC of the accepted fence and presents the next sequential
// address as the fetch restart point.
// Assumes: capture is high only in the cycle the fence is accepted.
module ifs_redirect
    import ifs_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] redirect_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] pc_q;

    // Hold the fence address for the length of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (capture) begin
            pc_q <= pc_in;
        end
    end

    // Restart just after the fence; wraps at the top of the address space.
    always_comb begin
        redirect_pc = pc_q + STEP;
    end

endmodule

// File: rtl/ifence_seq.sv
// Module: ifence_seq (top)
// Instruction-fetch fence sequencer. Accepts instructions while idle, starts
// the sequence on a fetch fence, blocks issue until the flush cycle ends.
// Assumes: decode holds dec_instr/dec_pc stable while dec_valid is high, and
// the store buffer reports empty within finite time.
module ifence_seq
    import ifs_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter bit COHERENT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    output logic               dec_ready,
    input  logic [INSTR_W-1:0] dec_instr,
    input  logic [PC_W-1:0]    dec_pc,
    input  logic               sb_empty,
    output logic               dc_wb_req,
    input  logic               dc_wb_done,
    output logic               ic_inv_req,
    input  logic               ic_inv_done,
    output logic               fetch_flush,
    output logic [PC_W-1:0]    fetch_redirect_pc
);

    logic is_fence;
    logic idle;
    logic accept;

    // Decode the fence from the incoming word.
    ifs_decode u_decode (
        .instr          (dec_instr),
        .is_fetch_fence (is_fence)
    );

    // Handshake: take a fence only when idle and offered.
    assign accept    = dec_valid && idle && is_fence;
    assign dec_ready = idle;

    // Sequence controller.
    ifs_seq_fsm #(
        .COHERENT (COHERENT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .sb_empty (sb_empty),
        .dc_done  (dc_wb_done),
        .ic_done  (ic_inv_done),
        .idle     (idle),
        .dc_req   (dc_wb_req),
        .ic_req   (ic_inv_req),
        .flush    (fetch_flush)
    );

    // Restart address for the flush.
    ifs_redirect #(
        .PC_W (PC_W)
    ) u_redirect (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (accept),
        .pc_in       (dec_pc),
        .redirect_pc (fetch_redirect_pc)
    );

endmodule

// File: rtl/ifs_checker.sv
// Module: ifs_checker
// Protocol properties of the fence sequencer, observed at its ports.
// Assumes: bound to every ifence_seq instance by the bind below.
module ifs_checker #(
    parameter bit COHERENT = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic dec_ready,
    input logic sb_empty,
    input logic dc_wb_req,
    input logic dc_wb_done,
    input logic ic_inv_req,
    input logic ic_inv_done,
    input logic fetch_flush
);

    // R1: reset leaves the block idle with every request low.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (dec_ready && !dc_wb_req && !ic_inv_req && !fetch_flush));

    // R5: issue is blocked during the flush cycle.
    p_flush_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |-> !dec_ready);

    // R6: no progress out of the drain step while stores are pending.
    p_drain_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sb_empty && !dec_ready && !dc_wb_req && !ic_inv_req && !fetch_flush)
        |=> (!dc_wb_req && !fetch_flush));

    // R6: a write-back request starts only after the buffer was seen empty.
    p_wb_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dc_wb_req) |-> $past(sb_empty));

    // R7: the two cache requests are mutually exclusive.
    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dc_wb_req && ic_inv_req));

    // R7: write-back request holds until done.
    p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_wb_req && !dc_wb_done) |=> dc_wb_req);

    // R7: invalidate request holds until done.
    p_inv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_inv_req && !ic_inv_done) |=> ic_inv_req);

    // R7: invalidate directly follows a completed write-back.
    p_wb_then_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dc_wb_req) && $past(rst_n)) |-> ic_inv_req);

    // R8: coherent configuration never asks the caches for anything.
    p_coherent_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        COHERENT |-> (!dc_wb_req && !ic_inv_req));

    // R9: flush lasts one cycle and issue resumes right after it.
    p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |=> (!fetch_flush && dec_ready));

endmodule

bind ifence_seq ifs_checker #(
    .COHERENT (COHERENT)
) u_ifs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_ready   (dec_ready),
    .sb_empty    (sb_empty),
    .dc_wb_req   (dc_wb_req),
    .dc_wb_done  (dc_wb_done),
    .ic_inv_req  (ic_inv_req),
    .ic_inv_done (ic_inv_done),
    .fetch_flush (fetch_flush)
);

// File: tb/test_ifence_seq.sv
// Bench: sweeps drain/write-back/invalidate latencies on an incoherent
// instance and drain latency on a coherent one; expected cycle numbers are
// computed arithmetically from the requirements.
module test_ifence_seq;

    localparam int PC_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0]     instr = '0;
    logic [PC_W-1:0] pc = '0;
    logic            sb_empty = 1'b0;
    logic            dc_done = 1'b0;
    logic            ic_done = 1'b0;
    logic            val_i = 1'b0;
    logic            val_c = 1'b0;

    logic            rdy_i, dq_i, iq_i, fl_i;
    logic [PC_W-1:0] rpc_i;
    logic            rdy_c, dq_c, iq_c, fl_c;
    logic [PC_W-1:0] rpc_c;

    ifence_seq #(.PC_W(PC_W), .COHERENT(1'b0)) i_ifence_seq (
        .clk(clk), .rst_n(rst_n), .dec_valid(val_i), .dec_ready(rdy_i),
        .dec_instr(instr), .dec_pc(pc), .sb_empty(sb_empty),
        .dc_wb_req(dq_i), .dc_wb_done(dc_done), .ic_inv_req(iq_i),
        .ic_inv_done(ic_done), .fetch_flush(fl_i), .fetch_redirect_pc(rpc_i)
    );

    ifence_seq #(.PC_W(PC_W), .COHERENT(1'b1)) i_ifence_seq_coh (
        .clk(clk), .rst_n(rst_n), .dec_valid(val_c), .dec_ready(rdy_c),
        .dec_instr(instr), .dec_pc(pc), .sb_empty(sb_empty),
        .dc_wb_req(dq_c), .dc_wb_done(dc_done), .ic_inv_req(iq_c),
        .ic_inv_done(ic_done), .fetch_flush(fl_c), .fetch_redirect_pc(rpc_c)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] f3,
                                       input logic [11:0] imm, input logic [4:0] rs1,
                                       input logic [4:0] rd);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic o_rdy(input bit coh); return coh ? rdy_c : rdy_i; endfunction
    function automatic logic o_dq(input bit coh);  return coh ? dq_c : dq_i;   endfunction
    function automatic logic o_iq(input bit coh);  return coh ? iq_c : iq_i;   endfunction
    function automatic logic o_fl(input bit coh);  return coh ? fl_c : fl_i;   endfunction
    function automatic logic [PC_W-1:0] o_rpc(input bit coh); return coh ? rpc_c : rpc_i; endfunction

    // Runs one fence; called at a falling edge, returns at a falling edge
    // where the block is idle again. d = cycles sb_empty stays low in drain,
    // w/v = extra cycles before write-back/invalidate done.
    task automatic run_fence(input bit coh, input logic [31:0] ins,
                             input logic [PC_W-1:0] p, input int d, input int w,
                             input int v, input string t_time);
        int k, exp_k, first_wb, first_inv, wcnt, vcnt;
        bit seen, rdy_bad;
        chk(o_rdy(coh) == 1'b1, "R11", "ready before offer", o_rdy(coh), 1);
        instr = ins; pc = p;
        val_i = !coh; val_c = coh;
        sb_empty = (d == 0); dc_done = 1'b0; ic_done = 1'b0;
        @(posedge clk);
        @(negedge clk);
        val_i = 1'b0; val_c = 1'b0;
        instr = 32'h0000_0013; pc = ~p;
        exp_k = coh ? 2 + d : 4 + d + w + v;
        first_wb = -1; first_inv = -1; wcnt = 0; vcnt = 0;
        seen = 1'b0; rdy_bad = 1'b0; k = 1;
        while (!seen && k < 60) begin
            if (o_fl(coh)) begin
                seen = 1'b1;
                dc_done = 1'b0; ic_done = 1'b0;
                chk(k == exp_k, t_time, "flush cycle", k, exp_k);
                chk(o_rpc(coh) == p + 32'd4, "R9", "redirect pc", o_rpc(coh), p + 32'd4);
            end else begin
                if (o_rdy(coh)) rdy_bad = 1'b1;
                if (o_dq(coh) && first_wb < 0) first_wb = k;
                if (o_iq(coh) && first_inv < 0) first_inv = k;
                if (o_dq(coh) && o_iq(coh)) first_inv = -99;
                sb_empty = (k >= 1 + d);
                dc_done = o_dq(coh) && (wcnt == w);
                if (o_dq(coh)) wcnt++;
                ic_done = o_iq(coh) && (vcnt == v);
                if (o_iq(coh)) vcnt++;
                @(negedge clk);
                k++;
            end
        end
        chk(seen, "R9", "flush seen", seen, 1);
        chk(!rdy_bad, "R5", "ready low while busy", rdy_bad, 0);
        if (coh) begin
            chk(first_wb < 0 && first_inv < 0, "R8", "no cache request", first_wb, -1);
        end else begin
            chk(first_wb == 2 + d, "R6", "write-back start", first_wb, 2 + d);
            chk(first_inv == 3 + d + w, "R7", "invalidate start", first_inv, 3 + d + w);
        end
        @(negedge clk);
        chk(!o_fl(coh) && o_rdy(coh), "R9", "one-cycle flush then ready",
            {o_fl(coh), o_rdy(coh)}, 2'b01);
    endtask

    // Offers a non-triggering word to both instances and watches for effects.
    task automatic offer_ignored(input logic [31:0] ins, input bit valid, input string req);
        bit bad;
        bad = 1'b0;
        instr = ins; pc = 32'h0000_2000;
        val_i = valid; val_c = valid; sb_empty = 1'b1;
        @(posedge clk);
        @(negedge clk);
        val_i = 1'b0; val_c = 1'b0;
        for (int c = 0; c < 4; c++) begin
            if (!rdy_i || !rdy_c || dq_i || iq_i || fl_i || fl_c || dq_c || iq_c) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, req, "word has no effect", ins, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state on both variants.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rdy_i && !dq_i && !iq_i && !fl_i, "R1", "incoherent reset outputs",
            {rdy_i, dq_i, iq_i, fl_i}, 4'b1000);
        chk(rdy_c && !dq_c && !iq_c && !fl_c, "R1", "coherent reset outputs",
            {rdy_c, dq_c, iq_c, fl_c}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every other funct3 on the fence opcode, including the data fence.
        for (int f = 0; f < 8; f++) begin
            if (f != 1) offer_ignored(mk(7'b0001111, 3'(f), 12'h0ff, 5'd0, 5'd0), 1'b1, "R3");
        end
        // R3: neighbouring opcodes with funct3 001.
        offer_ignored(mk(7'b0010011, 3'b001, 12'h000, 5'd1, 5'd1), 1'b1, "R3");
        offer_ignored(mk(7'b0001110, 3'b001, 12'h000, 5'd0, 5'd0), 1'b1, "R3");
        offer_ignored(mk(7'b1001111, 3'b001, 12'h000, 5'd0, 5'd0), 1'b1, "R3");
        offer_ignored(mk(7'b0001011, 3'b001, 12'h000, 5'd0, 5'd0), 1'b1, "R3");
        // R2: a real fence that is not valid is not taken.
        offer_ignored(mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0), 1'b0, "R2");

        // R10 / R4: coherent drain sweep, zero and non-zero reserved fields.
        for (int d = 0; d < 4; d++) begin
            run_fence(1'b1, mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0),
                      32'h0000_1000 + 32'(d * 16), d, 0, 0, "R10");
            run_fence(1'b1, mk(7'b0001111, 3'b001, 12'hfff, 5'd31, 5'd31),
                      32'h0000_4000 + 32'(d * 16), d, 0, 0, "R4");
        end

        // R7 / R6 / R4: incoherent sweep of drain, write-back, invalidate delays,
        // back to back, with reserved fields varied per run.
        for (int d = 0; d < 3; d++) begin
            for (int w = 0; w < 3; w++) begin
                for (int v = 0; v < 3; v++) begin
                    run_fence(1'b0,
                              mk(7'b0001111, 3'b001, 12'(d * 397 + w * 91 + v * 13),
                                 5'(d * 9 + v), 5'(w * 7 + v)),
                              32'h0008_0000 + 32'(d * 64 + w * 8 + v * 4), d, w, v, "R7");
                end
            end
        end

        // R9: redirect wraps at the top of the address space.
        run_fence(1'b0, mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0),
                  32'hffff_fffc, 0, 0, 0, "R7");

        // R11: explicit back-to-back pair on each variant.
        run_fence(1'b0, mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0),
                  32'h0000_0100, 1, 1, 1, "R7");
        run_fence(1'b0, mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0),
                  32'h0000_0104, 0, 0, 0, "R11");
        run_fence(1'b1, mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0),
                  32'h0000_0200, 0, 0, 0, "R10");
        run_fence(1'b1, mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0),
                  32'h0000_0204, 0, 0, 0, "R11");

        // R1: reset in the middle of a write-back request.
        instr = mk(7'b0001111, 3'b001, 12'h000, 5'd0, 5'd0);
        pc = 32'h0000_3000; val_i = 1'b1; sb_empty = 1'b1; dc_done = 1'b0; ic_done = 1'b0;
        @(posedge clk);
        @(negedge clk);
        val_i = 1'b0;
        @(negedge clk);
        chk(dq_i, "R7", "write-back request raised", dq_i, 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rdy_i && !dq_i && !iq_i && !fl_i, "R1", "mid-sequence reset",
            {rdy_i, dq_i, iq_i, fl_i}, 4'b1000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rdy_i && !dq_i && !iq_i && !fl_i, "R1", "idle after reset release",
            {rdy_i, dq_i, iq_i, fl_i}, 4'b1000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule